// File: doc/BRIEF.md
# Serial ADC Control and Data Sequencer

This block is the digital front end of an eight-channel, 10-bit serial analog-to-digital converter. It sits on a single system clock. The serial data clock and the conversion clock arrive as ordinary inputs, and the block finds their edges itself. The host lowers chip select and sends a short command on the data-in line. The first three bits of the command name the input channel and the fourth bit picks the output format. Ten serial clocks after chip select falls, the sampling window closes and a conversion runs for a fixed number of conversion-clock cycles. While that command goes in, the result of the previous conversion comes out on the data-out line.

The converted value arrives on a parallel port and is captured at the moment the busy status drops. It is placed in a 16-bit parallel-load shift register. In left format the MSB leads and zeros fill the tail. In right format six zeros come first and then the MSB. The data-out tri-state is shown as a separate enable output. A host that keeps chip select low can wait for busy to fall and read the first bit before it issues any serial clock.

Top module: `adc_serial_seq`

## Requirements
- R1: While cs_n is low and busy is low, each rising sclk edge takes one di bit. The first three bits of an exchange, most significant first, form the channel number, and chan shows it once the fourth bit has been taken.
- R2: The fourth bit of an exchange sets the format of the next result: 0 selects left format and 1 selects right format.
- R3: Each falling sclk edge with cs_n and oe_n both low moves the output register on by one bit, and do_bit always shows the leading bit. Falling edges while oe_n is high move nothing.
- R4: A left-format word is D9 down to D0 followed by six zeros. A right-format word is six zeros followed by D9 down to D0, which is 16 bits in all.
- R5: busy rises in the cycle after the tenth rising sclk edge of an exchange. It falls after it has counted 41 rising cclk edges while high.
- R6: In the cycle busy falls, the output register already holds conv_data, sampled on that same clock edge, in the selected format. do_bit presents the first bit of the word without any sclk edge.
- R7: do_en is high exactly when cs_n and oe_n are both low.
- R8: While busy is high, do_bit is 0.
- R9: Raising cs_n during a conversion does not change its length or its result. Raising cs_n also resets the exchange bit count.
- R10: Rising sclk edges during a conversion are ignored. With cs_n still low, a new exchange starts counting after busy falls.
- R11: After reset, busy is low, chan is 0 and the format is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| sclk | input | 1 | serial data clock, sampled |
| cclk | input | 1 | conversion clock, sampled |
| cs_n | input | 1 | chip select, active low |
| oe_n | input | 1 | output enable, active low |
| di | input | 1 | serial command bit |
| conv_data | input | 10 | converted value to capture |
| do_bit | output | 1 | serial result bit |
| do_en | output | 1 | data-out drive enable (low means high impedance) |
| busy | output | 1 | conversion in progress |
| chan | output | 3 | selected channel |

## Verification
A wrong exchange bit count shows at the ports within one serial clock:
- busy rises early or late;
- or chan picks up the wrong bits.

A wrong conversion counter shows as a busy pulse of the wrong length in the same conversion. A wrong output register or format shows on do_bit in the very cycle busy falls, and then on every later falling sclk edge. The bench compares against a queue-based model on every clock, so a fault appears at its first visible cycle.

// File: rtl/adc_serial_seq.sv
module adc_serial_seq #(
  parameter int DATA_W      = 10,
  parameter int WORD_W      = 16,
  parameter int CHAN_BITS   = 3,
  parameter int XFER_EDGES  = 10,
  parameter int CONV_CYCLES = 41
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cclk,
  input  logic                 cs_n,
  input  logic                 oe_n,
  input  logic                 di,
  input  logic [DATA_W-1:0]    conv_data,
  output logic                 do_bit,
  output logic                 do_en,
  output logic                 busy,
  output logic [CHAN_BITS-1:0] chan
);
  localparam int PAD_W = WORD_W - DATA_W;
  localparam int CNT_W = $clog2(XFER_EDGES + 1);
  localparam int CC_W  = $clog2(CONV_CYCLES);

  logic                 sclk_q, cclk_q;
  logic [CNT_W-1:0]     bit_cnt;
  logic [CHAN_BITS-1:0] addr_sh, chan_r;
  logic                 fmt_r;
  logic                 busy_r;
  logic [CC_W-1:0]      cc_cnt;
  logic [WORD_W-1:0]    out_sh;

  wire s_rise    = sclk & ~sclk_q;
  wire s_fall    = ~sclk & sclk_q;
  wire c_rise    = cclk & ~cclk_q;
  wire conv_done = busy_r & c_rise & (cc_cnt == CC_W'(CONV_CYCLES - 1));
  wire take_bit  = ~cs_n & ~busy_r & s_rise;
  wire start     = take_bit & (bit_cnt == CNT_W'(XFER_EDGES - 1));
  wire shift_out = s_fall & ~cs_n & ~oe_n;

  wire [WORD_W-1:0] load_word = fmt_r ? {{PAD_W{1'b0}}, conv_data}
                                      : {conv_data, {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cclk_q  <= 1'b0;
      bit_cnt <= '0;
      addr_sh <= '0;
      chan_r  <= '0;
      fmt_r   <= 1'b0;
      busy_r  <= 1'b0;
      cc_cnt  <= '0;
      out_sh  <= '0;
    end else begin
      sclk_q <= sclk;
      cclk_q <= cclk;

      if (cs_n || conv_done)
        bit_cnt <= '0;
      else if (take_bit)
        bit_cnt <= bit_cnt + 1'b1;

      if (take_bit && bit_cnt < CNT_W'(CHAN_BITS))
        addr_sh <= {addr_sh[CHAN_BITS-2:0], di};

      if (take_bit && bit_cnt == CNT_W'(CHAN_BITS)) begin
        chan_r <= addr_sh;
        fmt_r  <= di;
      end

      if (conv_done)
        busy_r <= 1'b0;
      else if (start) begin
        busy_r <= 1'b1;
        cc_cnt <= '0;
      end else if (busy_r && c_rise)
        cc_cnt <= cc_cnt + 1'b1;

      if (conv_done)
        out_sh <= load_word;
      else if (shift_out)
        out_sh <= {out_sh[WORD_W-2:0], 1'b0};
    end
  end

  assign do_en  = ~cs_n & ~oe_n;
  assign do_bit = do_en & ~busy_r & out_sh[WORD_W-1];
  assign busy   = busy_r;
  assign chan   = chan_r;
endmodule

module adc_serial_seq_chk #(
  parameter int DATA_W      = 10,
  parameter int CONV_CYCLES = 41
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cclk,
  input logic              cs_n,
  input logic [DATA_W-1:0] conv_data,
  input logic              do_bit,
  input logic              do_en,
  input logic              busy,
  input logic              fmt_r
);
  logic       cclk_d;
  logic [7:0] rises;
  wire c_up = cclk & ~cclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cclk_d <= 1'b0;
      rises  <= '0;
    end else begin
      cclk_d <= cclk;
      if (!busy) rises <= '0;
      else if (c_up) rises <= rises + 1'b1;
    end
  end

  p_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !do_en);
  p_zero_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_en) |-> !do_bit);
  p_end_on_cclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(c_up));
  p_conv_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(rises) == CONV_CYCLES));
  p_conv_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(rises) < CONV_CYCLES));
  p_first_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && do_en) |-> (do_bit == (fmt_r ? 1'b0 : $past(conv_data[DATA_W-1]))));
endmodule

bind adc_serial_seq adc_serial_seq_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cclk(cclk), .cs_n(cs_n), .conv_data(conv_data),
  .do_bit(do_bit), .do_en(do_en), .busy(busy), .fmt_r(fmt_r)
);

// File: tb/adc_serial_seq_test.sv
`timescale 1ns/1ps
module adc_serial_seq_test;
  logic clk = 0, rst_n = 0, sclk = 0, cclk = 0, cs_n = 1, oe_n = 0, di = 0;
  logic [9:0] conv_data = '0;
  logic do_bit, do_en, busy;
  logic [2:0] chan;

  adc_serial_seq uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cclk(cclk), .cs_n(cs_n),
    .oe_n(oe_n), .di(di), .conv_data(conv_data), .do_bit(do_bit), .do_en(do_en),
    .busy(busy), .chan(chan));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit checking = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  int cdiv = 0;
  always @(negedge clk) begin
    cdiv++;
    if (cdiv == 2) begin cclk <= ~cclk; cdiv = 0; end
  end

  // behavioural reference
  bit sp, cp, busy_m, rj_m, known;
  int nb, cc_m, acc, chan_m;
  int q[$];
  always @(posedge clk) begin
    bit sr, sf, cr, b0, endc;
    if (!rst_n) begin
      sp = 0; cp = 0; busy_m = 0; rj_m = 0; known = 0;
      nb = 0; cc_m = 0; acc = 0; chan_m = 0;
      q.delete();
      for (int i = 0; i < 16; i++) q.push_back(0);
    end else begin
      sr = sclk && !sp; sf = !sclk && sp; cr = cclk && !cp;
      sp = sclk; cp = cclk;
      b0 = busy_m;
      endc = b0 && cr && (cc_m == 40);
      if (endc) begin
        int word;
        busy_m = 0; known = 1;
        word = rj_m ? int'(conv_data) : (int'(conv_data) << 6);
        q.delete();
        for (int i = 0; i < 16; i++) q.push_back((word >> (15 - i)) & 1);
      end else if (b0 && cr) cc_m++;
      if (!endc && sf && !cs_n && !oe_n) begin
        void'(q.pop_front());
        q.push_back(0);
      end
      if (cs_n || endc) nb = 0;
      else if (!b0 && sr) begin
        if (nb < 3) acc = ((acc << 1) | int'(di)) & 7;
        else if (nb == 3) begin chan_m = acc; rj_m = di; end
        if (nb == 9) begin busy_m = 1; cc_m = 0; end
        nb++;
      end
    end
  end

  always @(negedge clk) if (rst_n && checking) begin
    bit exp_en;
    exp_en = !cs_n && !oe_n;
    chk(busy === busy_m, "R5 R9 busy", int'(busy), int'(busy_m));
    chk(chan === chan_m[2:0], "R1 R10 channel", int'(chan), chan_m);
    chk(do_en === exp_en, "R7 do_en", int'(do_en), int'(exp_en));
    if (exp_en && busy_m) chk(do_bit === 1'b0, "R8 do_bit busy", int'(do_bit), 0);
    else if (exp_en && known) chk(do_bit === q[0][0], "R2 R3 R4 R6 do_bit", int'(do_bit), q[0]);
  end

  task automatic sclk_cycle(input bit b);
    di = b; sclk = 1;
    repeat (2) @(negedge clk);
    sclk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic exch(input int ch, input bit rj, input int n);
    cs_n = 0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bit b;
      if (i < 3) b = ch[2 - i];
      else if (i == 3) b = rj;
      else b = i[0];
      sclk_cycle(b);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R11 reset busy", int'(busy), 0);
    chk(chan === 3'd0, "R11 reset chan", int'(chan), 0);
    rst_n = 1; checking = 1;
    @(negedge clk);
    // first conversion, left, hold cs low across busy fall (R6)
    conv_data = 10'h1A5;
    exch(5, 0, 10); wait_idle(); cs_n = 1; repeat (4) @(negedge clk);
    // right format; extra clocks during busy ignored (R10)
    conv_data = 10'h2B5;
    exch(3, 1, 16); wait_idle();
    conv_data = 10'h3FF;
    exch(6, 0, 16); wait_idle(); cs_n = 1; repeat (4) @(negedge clk);
    // oe high: no shifting (R3, R7)
    oe_n = 1; conv_data = 10'h0F0;
    exch(1, 1, 12); wait_idle(); cs_n = 1; oe_n = 0; repeat (4) @(negedge clk);
    // cs raised during conversion (R9)
    conv_data = 10'h000;
    exch(7, 0, 10); cs_n = 1;
    for (int i = 0; i < 5; i++) sclk_cycle(1'b1);
    wait_idle();
    conv_data = 10'h155;
    exch(2, 1, 16); wait_idle();
    conv_data = 10'h2AA;
    exch(4, 0, 16); wait_idle();
    exch(0, 0, 16); wait_idle(); cs_n = 1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    checking = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule